// File: doc/BRIEF.md
# Single-Port Bus Memory Target

This block is a word-organised memory that answers a simple ready/valid bus. Reads and writes arrive on one shared command channel. Each command carries an address, a read/write select and an access size. Write data arrives on its own channel, and the handshake on that channel also completes the write. Read results go back on a third channel with a one-bit OK/error response. The target handles one transaction at a time and never moves more than one data beat per command.

Storage is built as one byte-wide array per byte lane. This lets a write touch any subset of the four lanes. A lane is written only when two conditions hold: the requester's strobe selects it, and the lane lies inside the byte, halfword or word that the command addresses. An access that is misaligned for its size, or that carries the unused size code, is flagged as an error. Such a read returns an error response with zeroed data. Such a write finishes its handshake but leaves the storage untouched. Read data is always the whole addressed word in its natural lanes, so the requester picks the bytes it needs.

Top module: `cbm_slave`

## Requirements
- R1: While reset is held and directly after it is released, cmdReady is 1, and rValid and wReady are 0.
- R2: Only one transaction is in flight. Once a command is accepted (cmdValid and cmdReady both high at a clock edge), cmdReady stays 0 until the matching write-data or read-data handshake completes, and it returns to 1 in the cycle after that handshake.
- R3: A read command (cmdWrite=0) accepted at an edge raises rValid in the following cycle. rData is then the 32-bit storage word selected by the address, with byte lane i on bits 8i+7..8i.
- R4: While rValid is 1 and rReady is 0, rValid, rData and rResp hold their values.
- R5: A write command (cmdWrite=1) accepted at an edge raises wReady in the following cycle. The write takes effect at the edge where wValid and wReady are both 1. Strobe bit i enables byte lane i (wData bits 8i+7..8i), and lanes whose strobe bit is 0 keep their contents.
- R6: The size code selects the lanes a write may touch. Code 0 (byte) allows only lane addr[1:0]. Code 1 (halfword) allows lanes 2*addr[1] and 2*addr[1]+1. Code 2 (word) allows all four lanes. A strobed lane outside this set is not written.
- R7: An access is an error when it is a halfword with addr[0]=1, a word with addr[1:0]!=0, or uses size code 3. An erroneous read returns rResp=1 and rData=0. An erroneous write completes its handshake but changes no storage.
- R8: A read without error returns rResp=0.
- R9: Only address bits [IDX_W+1:2] choose the word, where IDX_W is log2 of DEPTH_WORDS. Higher address bits are ignored, so addresses that differ by a multiple of DEPTH_WORDS*4 refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Target can accept a command |
| cmdWrite | input | 1 | 0 = read, 1 = write |
| cmdAddr | input | 32 | Byte address of the access |
| cmdSize | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = invalid |
| wValid | input | 1 | Write data offered |
| wReady | output | 1 | Target waiting for write data |
| wStrb | input | 4 | Byte-lane enables for the write |
| wData | input | 32 | Write data in natural lanes |
| rValid | output | 1 | Read result offered |
| rReady | input | 1 | Requester takes the read result |
| rResp | output | 1 | 0 = OK, 1 = error |
| rData | output | 32 | Read word, zero on error |

## Verification
On every cycle, assertions check the channel sequencing. This covers the one-outstanding rule, the cycle after acceptance in which wReady or rValid must rise, cmdReady returning after a handshake, and the read result holding steady under back-pressure. Only the bench scenarios can show what ends up in storage. That includes lane masking by strobe and by size footprint, misaligned writes leaving words intact, zeroed data on error reads, and address aliasing. The bench shows these by reading words back and comparing them against a model memory.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WDATA = 2'd1,
    ST_RRESP = 2'd2
  } cbmState_t;

  typedef struct packed {
    logic acceptCmd;
    logic commitWrite;
    logic releaseRead;
  } cbmStrobes_t;
endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdWrite,
  input  logic        wValid,
  input  logic        rReady,
  output logic        cmdReady,
  output logic        wReady,
  output logic        rValid,
  output cbmStrobes_t strobes
);
  cbmState_t stateQ, stateD;

  always_comb begin
    cmdReady = (stateQ == ST_IDLE);
    wReady   = (stateQ == ST_WDATA);
    rValid   = (stateQ == ST_RRESP);
    strobes.acceptCmd   = cmdReady && cmdValid;
    strobes.commitWrite = wReady && wValid;
    strobes.releaseRead = rValid && rReady;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (strobes.acceptCmd) stateD = cmdWrite ? ST_WDATA : ST_RRESP;
      ST_WDATA: if (strobes.commitWrite) stateD = ST_IDLE;
      ST_RRESP: if (strobes.releaseRead) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R3: an accepted read raises rValid in the next cycle
  assert_read_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && !cmdWrite |=> rValid && !cmdReady && !wReady);

  // R5: an accepted write raises wReady in the next cycle
  assert_write_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && cmdWrite |=> wReady && !cmdReady && !rValid);

  // R2: command channel reopens after either data handshake
  assert_reopen_after_hs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && wReady) || (rValid && rReady) |=> cmdReady);

  // R2: busy until the data channel finishes
  assert_stay_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wReady && !wValid) || (rValid && !rReady) |=> !cmdReady);

  // R4: read result is not withdrawn under back-pressure
  assert_rvalid_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid);
endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbmStrobes_t       strobes,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [1:0]        cmdSize,
  input  logic [LANES-1:0]  wStrb,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic              rResp
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);

  logic [IDX_W-1:0]  cmdIdx;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [LANES-1:0]  laneMaskQ;
  logic [LANES-1:0]  footprint;
  logic              misaligned;
  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] rDataQ;
  logic              rRespQ;
  logic              unusedBits;

  assign cmdIdx     = cmdAddr[IDX_W+1:2];
  assign unusedBits = ^{cmdAddr[ADDR_W-1:IDX_W+2], strobes.releaseRead};

  always_comb begin
    unique case (cmdSize)
      SIZE_BYTE: misaligned = 1'b0;
      SIZE_HALF: misaligned = cmdAddr[0];
      SIZE_WORD: misaligned = (cmdAddr[1:0] != 2'b00);
      default:   misaligned = 1'b1;
    endcase
    unique case (cmdSize)
      SIZE_BYTE: footprint = LANES'(1) << cmdAddr[1:0];
      SIZE_HALF: footprint = LANES'(3) << {cmdAddr[1], 1'b0};
      SIZE_WORD: footprint = {LANES{1'b1}};
      default:   footprint = '0;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] laneMem [DEPTH_WORDS];
    always_ff @(posedge clk) begin
      if (strobes.commitWrite && laneMaskQ[g] && wStrb[g])
        laneMem[wrIdxQ] <= wData[8*g +: 8];
    end
    assign readWord[8*g +: 8] = laneMem[cmdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdxQ    <= '0;
      laneMaskQ <= '0;
      rDataQ    <= '0;
      rRespQ    <= 1'b0;
    end else if (strobes.acceptCmd) begin
      wrIdxQ    <= cmdIdx;
      laneMaskQ <= misaligned ? '0 : footprint;
      rDataQ    <= misaligned ? '0 : readWord;
      rRespQ    <= misaligned;
    end
  end

  assign rData = rDataQ;
  assign rResp = rRespQ;

  // R7: a write with an empty lane mask must come from an erroneous command
  assert_masked_write_is_error_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWrite && (laneMaskQ == '0) |-> rRespQ);
endmodule

// File: rtl/cbm_slave.sv
module cbm_slave
  import cbm_pkg::*;
#(
  parameter int DEPTH_WORDS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic        cmdWrite,
  input  logic [31:0] cmdAddr,
  input  logic [1:0]  cmdSize,
  input  logic        wValid,
  output logic        wReady,
  input  logic [3:0]  wStrb,
  input  logic [31:0] wData,
  output logic        rValid,
  input  logic        rReady,
  output logic        rResp,
  output logic [31:0] rData
);
  cbmStrobes_t strobes;

  cbm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .wValid(wValid), .rReady(rReady), .cmdReady(cmdReady),
    .wReady(wReady), .rValid(rValid), .strobes(strobes)
  );

  cbm_datapath #(.DEPTH_WORDS(DEPTH_WORDS), .ADDR_W(32)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdAddr(cmdAddr),
    .cmdSize(cmdSize), .wStrb(wStrb), .wData(wData),
    .rData(rData), .rResp(rResp)
  );

  // R4: result payload frozen while the requester stalls
  assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> $stable(rData) && $stable(rResp));

  // R7: an error response never carries data
  assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    rValid && rResp |-> rData == 32'h0);
endmodule

// File: tb/cbm_slave_tb_top.sv
module cbm_slave_tb_top;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic [1:0]  cmdSize = '0;
  logic        wValid = 1'b0;
  logic [3:0]  wStrb = '0;
  logic [31:0] wData = '0;
  logic        rReady = 1'b0;
  logic        cmdReady, wReady, rValid, rResp;
  logic [31:0] rData;

  always #4 clk = ~clk;

  cbm_slave #(.DEPTH_WORDS(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdSize(cmdSize),
    .wValid(wValid), .wReady(wReady), .wStrb(wStrb), .wData(wData),
    .rValid(rValid), .rReady(rReady), .rResp(rResp), .rData(rData)
  );

  typedef struct { logic resp; logic [31:0] data; } expItem_t;
  expItem_t    expQ[$];
  logic [31:0] model [DEPTH];
  int nChecks = 0, nFails = 0;
  int readStall = 0;
  bit done = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isErr(logic [31:0] a, logic [1:0] s);
    case (s)
      2'd0: return 1'b0;
      2'd1: return a[0];
      2'd2: return a[1:0] != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] lanesOf(logic [31:0] a, logic [1:0] s);
    case (s)
      2'd0: return 4'b0001 << a[1:0];
      2'd1: return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic doWrite(logic [31:0] a, logic [1:0] s, logic [3:0] st,
                         logic [31:0] d, int delay);
    int idx;
    logic [3:0] m;
    while (!cmdReady) @(negedge clk);
    cmdValid = 1; cmdWrite = 1; cmdAddr = a; cmdSize = s;
    @(negedge clk);
    cmdValid = 0;
    check(cmdReady == 0, "R2 busy after write accept", {31'b0, cmdReady}, 0);
    check(wReady == 1, "R5 wReady after write accept", {31'b0, wReady}, 1);
    repeat (delay) @(negedge clk);
    wValid = 1; wStrb = st; wData = d;
    @(negedge clk);
    wValid = 0;
    check(cmdReady == 1, "R2 reopen after write", {31'b0, cmdReady}, 1);
    if (!isErr(a, s)) begin
      idx = a[7:2];
      m = lanesOf(a, s) & st;
      for (int i = 0; i < 4; i++)
        if (m[i]) model[idx][8*i +: 8] = d[8*i +: 8];
    end
  endtask

  task automatic doRead(logic [31:0] a, logic [1:0] s, int stall);
    expItem_t e;
    while (!cmdReady) @(negedge clk);
    if (isErr(a, s)) begin e.resp = 1; e.data = 0; end
    else begin e.resp = 0; e.data = model[a[7:2]]; end
    expQ.push_back(e);
    readStall = stall;
    cmdValid = 1; cmdWrite = 0; cmdAddr = a; cmdSize = s;
    @(negedge clk);
    cmdValid = 0;
    check(cmdReady == 0, "R2 busy after read accept", {31'b0, cmdReady}, 0);
    while (!cmdReady) @(negedge clk);
  endtask

  // scoreboard monitor
  logic [31:0] snapData;
  logic        snapResp;
  bit          holding = 0;
  int          left = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (rValid && !rReady) begin
        if (!holding) begin
          holding = 1; snapData = rData; snapResp = rResp; left = readStall;
        end else begin
          check(rData === snapData && rResp === snapResp, "R4 stable under stall",
                rData, snapData);
        end
        if (left == 0) begin
          if (expQ.size() == 0) check(0, "R3 unexpected read result", rData, 0);
          else begin
            expItem_t e;
            e = expQ.pop_front();
            check(rResp === e.resp, e.resp ? "R7 error resp" : "R8 ok resp",
                  {31'b0, rResp}, {31'b0, e.resp});
            check(rData === e.data, e.resp ? "R7 error data zero" : "R3 read data",
                  rData, e.data);
          end
          rReady = 1;
        end else left--;
      end else begin
        rReady = 0;
        holding = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmdReady == 1 && rValid == 0 && wReady == 0, "R1 state in reset",
          {29'b0, cmdReady, rValid, wReady}, 32'h4);
    rstN = 1;
    @(negedge clk);
    check(cmdReady == 1 && rValid == 0 && wReady == 0, "R1 state after reset",
          {29'b0, cmdReady, rValid, wReady}, 32'h4);

    // fill all words (R5)
    for (int i = 0; i < DEPTH; i++)
      doWrite(i * 4, 2'd2, 4'hF, 32'h1000_0000 + i * 32'h0101_0101, 0);
    for (int i = 0; i < DEPTH; i += 7) doRead(i * 4, 2'd2, 0);   // R3, R8

    doWrite(32'h0, 2'd2, 4'hF, 32'h1122_3344, 2);                // R5 delayed data
    doRead(32'h0, 2'd2, 0);
    doWrite(32'h0, 2'd2, 4'b0101, 32'hAAAA_AAAA, 0);             // R5 partial strobe
    doRead(32'h0, 2'd2, 0);

    doWrite(32'h5, 2'd0, 4'hF, 32'hAABB_CCDD, 0);                // R6 byte lane 1
    doRead(32'h4, 2'd2, 0);
    doWrite(32'hA, 2'd1, 4'hF, 32'h5566_7788, 1);                // R6 upper half
    doRead(32'h8, 2'd2, 0);
    doWrite(32'hE, 2'd1, 4'b0100, 32'hFFFF_FFFF, 0);             // R6 half, one lane strobed
    doRead(32'hC, 2'd2, 0);
    doRead(32'hD, 2'd0, 0);                                      // byte read: whole word

    doWrite(32'h12, 2'd2, 4'hF, 32'hDEAD_BEEF, 0);               // R7 misaligned word
    doRead(32'h10, 2'd2, 0);
    doWrite(32'h15, 2'd1, 4'hF, 32'hDEAD_BEEF, 0);               // R7 odd halfword
    doWrite(32'h14, 2'd3, 4'hF, 32'hDEAD_BEEF, 0);               // R7 size code 3
    doRead(32'h14, 2'd2, 0);
    doRead(32'h3, 2'd1, 0);                                      // R7 error read
    doRead(32'h8, 2'd3, 1);                                      // R7 size 3 read

    doWrite(32'h104, 2'd2, 4'hF, 32'hCAFE_F00D, 0);              // R9 alias
    doRead(32'h4, 2'd2, 0);
    doRead(32'hFFFF_FF04, 2'd2, 0);

    doRead(32'h20, 2'd2, 3);                                     // R4 stall
    doRead(32'h7, 2'd1, 2);                                      // R4 stall on error

    while (!cmdReady) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R3 all reads answered", expQ.size(), 0);
    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule